// File: doc/BRIEF.md
# Power-of-Two I/O Window Decoder

This block decides whether a host I/O cycle falls inside one of the I/O windows that have been set up for the card sockets. Each socket owns two windows, numbered 0 and 1. A window is described by two registers. The base word holds the window start ORed with half the window length, so the size is carried by the lowest set bit of the word rather than by a stored limit. The control word holds an enable bit, a single-port flag, a socket-select field, a bus-width field and a wait-state count.

Software programs the windows through a small register port with a combinational read-back. The host side presents an address, the socket the cycle is aimed at, and a strobe. One clock later the block reports whether a window hit, and if so which window and bank won. It also reports the bus width and the wait-state count of that window, and the wait time in nanoseconds. The wait time is derived from a clock-period parameter, 70 ns by default.

Top module: `iowin_decode`

## Requirements
- R1: After reset every base and control word reads as zero and `hit` is low, so every window is disabled.
- R2: A write to a valid window stores the base word exactly. The control word reads back as enable in bit 15, single-port in bit 14, width in bits 12:11, socket select in bits 10:8 and wait count in bits 3:0. Bits 7:4 always read zero.
- R3: A register access with window index 2 or 3 is rejected. The write changes no register and the read returns zero.
- R4: A window without the single-port flag matches every address that equals the base word in all bits above its lowest set bit. The span is the lowest set bit together with all bits below it. A base word of zero spans the whole address space.
- R5: A window with the single-port flag (control bit 14) matches only the address equal to its base word.
- R6: A window whose enable bit (control bit 15) is clear never produces a hit.
- R7: A window matches only when its socket-select field (control bits 10:8) equals `host_sock`.
- R8: When several windows match, the lowest window number wins. Among windows with the same number, the lowest socket bank wins.
- R9: `hit` and the other result outputs are registered. They show the outcome of a strobe one clock after the strobe is sampled. With no strobe, or no match, `hit` is low and `hit_win`, `hit_sock`, `hit_width`, `hit_wait` and `hit_wait_ns` are zero.
- R10: On a hit, `hit_width` and `hit_wait` carry the winning window's width field and wait count. `hit_wait_ns` equals count*CLK_NS/2 + 14.
- R11: Control bit 13 (quiet) reads as 1 exactly when the stored width field is fixed: 00 means 8-bit and 01 means 16-bit. The codes 10 and 11 select dynamic sizing and read quiet as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sock | input | SOCK_W | Register bank (socket) select |
| reg_win | input | 2 | Window index; only 0 and 1 are valid |
| reg_sel | input | 1 | 0 selects the base word, 1 selects the control word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data |
| host_strb | input | 1 | Host I/O cycle strobe |
| host_sock | input | SOCK_W | Socket the host cycle is aimed at |
| host_addr | input | AW | Host I/O address |
| hit | output | 1 | Registered window hit |
| hit_win | output | 1 | Winning window number |
| hit_sock | output | SOCK_W | Bank of the winning window |
| hit_width | output | 2 | Width field of the winning window |
| hit_wait | output | 4 | Wait count of the winning window |
| hit_wait_ns | output | NS_W | Wait time in nanoseconds |

## Verification
The bench probes the first and last address of each window and the addresses just outside it. A design that clears or keeps the wrong bit when recovering the start would be off by one window half at those edges. Single-port windows are tested one address away from the port, where a design that ignored the flag would still hit. Overlapping windows in different banks and with different numbers expose a wrong priority order. Writes with window index 2 or 3 are followed by read-back and by strobes: a design that aliased index 2 onto window 0 would change a read value or a hit.

// File: rtl/iowin_decode.sv
module iowin_decode #(
  parameter int NUM_SOCK  = 2,
  parameter int AW        = 16,
  parameter int CLK_NS    = 70,
  parameter int WS_OFS_NS = 14,
  parameter int NS_W      = 16,
  parameter int SOCK_W    = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SOCK_W-1:0] reg_sock,
  input  logic [1:0]        reg_win,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              host_strb,
  input  logic [SOCK_W-1:0] host_sock,
  input  logic [AW-1:0]     host_addr,
  output logic              hit,
  output logic              hit_win,
  output logic [SOCK_W-1:0] hit_sock,
  output logic [1:0]        hit_width,
  output logic [3:0]        hit_wait,
  output logic [NS_W-1:0]   hit_wait_ns
);
  localparam int NWIN  = 2;
  localparam int NSLOT = NUM_SOCK * NWIN;

  logic [NSLOT-1:0][AW-1:0] base_q;
  logic [NSLOT-1:0][15:0]   ctrl_q;
  logic [NSLOT-1:0]         slot_m;

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    localparam int WI = gi / NUM_SOCK;
    localparam int SI = gi % NUM_SOCK;
    logic          sel;
    logic [AW-1:0] span;
    logic          range_m;
    assign sel     = (reg_win == 2'(WI)) && (reg_sock == SOCK_W'(SI));
    assign span    = base_q[gi] ^ (base_q[gi] - AW'(1));
    assign range_m = ((host_addr ^ base_q[gi]) & ~span) == '0;
    assign slot_m[gi] = ctrl_q[gi][15] && (ctrl_q[gi][10:8] == 3'(host_sock)) &&
                        (ctrl_q[gi][14] ? (host_addr == base_q[gi]) : range_m);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[gi] <= '0;
        ctrl_q[gi] <= '0;
      end else if (reg_we && sel) begin
        if (reg_sel)
          ctrl_q[gi] <= {reg_wdata[15:14], ~reg_wdata[12], reg_wdata[12:8], 4'b0, reg_wdata[3:0]};
        else
          base_q[gi] <= reg_wdata[AW-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (reg_win == 2'(i / NUM_SOCK) && reg_sock == SOCK_W'(i % NUM_SOCK))
        reg_rdata = reg_sel ? ctrl_q[i] : 16'(base_q[i]);
  end

  logic        any_m;
  logic        win_n;
  logic [SOCK_W-1:0] sock_n;
  logic [15:0] ctrl_n;

  always_comb begin
    any_m  = 1'b0;
    win_n  = 1'b0;
    sock_n = '0;
    ctrl_n = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot_m[i]) begin
        any_m  = 1'b1;
        win_n  = 1'(i / NUM_SOCK);
        sock_n = SOCK_W'(i % NUM_SOCK);
        ctrl_n = ctrl_q[i];
      end
  end

  logic take;
  assign take = host_strb && any_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit         <= 1'b0;
      hit_win     <= 1'b0;
      hit_sock    <= '0;
      hit_width   <= '0;
      hit_wait    <= '0;
      hit_wait_ns <= '0;
    end else begin
      hit         <= take;
      hit_win     <= take ? win_n : 1'b0;
      hit_sock    <= take ? sock_n : '0;
      hit_width   <= take ? ctrl_n[12:11] : 2'b0;
      hit_wait    <= take ? ctrl_n[3:0] : 4'b0;
      hit_wait_ns <= take ? NS_W'(int'(ctrl_n[3:0]) * CLK_NS / 2 + WS_OFS_NS) : '0;
    end
  end

  a_r9_hit_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !host_strb |=> !hit);
  a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_win == 1'b0 && hit_width == 2'b0 && hit_wait == 4'b0 && hit_wait_ns == '0));
  a_r3_bad_index_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_win[1]) |=> ($stable(base_q) && $stable(ctrl_q)));
  a_r6_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strb && slot_m == '0) |=> !hit);
  a_r10_wait_floor: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_wait_ns >= NS_W'(WS_OFS_NS));
  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_win[1]) |-> reg_rdata[7:4] == 4'b0);
endmodule

// File: tb/iowin_decode_tb_top.sv
module iowin_decode_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sock = 0, reg_sel = 0;
  logic [1:0] reg_win = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic host_strb = 0, host_sock = 0;
  logic [15:0] host_addr = 0;
  logic hit, hit_win, hit_sock;
  logic [1:0] hit_width;
  logic [3:0] hit_wait;
  logic [15:0] hit_wait_ns;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] mbase [2][2];
  logic [15:0] mctrl [2][2];

  always #4 clk = ~clk;

  iowin_decode dut_i (.clk, .rst_n, .reg_we, .reg_sock, .reg_win, .reg_sel, .reg_wdata,
    .reg_rdata, .host_strb, .host_sock, .host_addr, .hit, .hit_win, .hit_sock,
    .hit_width, .hit_wait, .hit_wait_ns);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(logic [15:0] d);
    logic [15:0] r = 0;
    r[15] = d[15]; r[14] = d[14];
    r[13] = (d[12:11] == 2'b00) || (d[12:11] == 2'b01);
    r[12:8] = d[12:8]; r[3:0] = d[3:0];
    return r;
  endfunction

  function automatic bit mt(logic [15:0] b, logic [15:0] c, logic s, logic [15:0] a);
    logic [15:0] sp = b ^ (b - 16'd1);
    if (!c[15]) return 0;
    if (c[10:8] != {2'b00, s}) return 0;
    if (c[14]) return a == b;
    return ((a ^ b) & ~sp) == 0;
  endfunction

  task automatic wr(int s, int w, bit sel, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_sock = 1'(s); reg_win = 2'(w); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (w < 2) begin
      if (sel) mctrl[s][w] = fmt(d); else mbase[s][w] = d;
    end
  endtask

  task automatic rd(string req, int s, int w, bit sel);
    @(negedge clk);
    reg_sock = 1'(s); reg_win = 2'(w); reg_sel = sel;
    #1;
    chk(req, {16'h0, reg_rdata}, {16'h0, (w < 2) ? (sel ? mctrl[s][w] : mbase[s][w]) : 16'h0});
  endtask

  task automatic probe(string req, bit strb, logic s, logic [15:0] a);
    bit eh = 0; bit ew = 0; bit es = 0; logic [15:0] c = 0;
    @(negedge clk);
    host_strb = strb; host_sock = s; host_addr = a;
    if (strb)
      for (int w = 1; w >= 0; w--)
        for (int k = 1; k >= 0; k--)
          if (mt(mbase[k][w], mctrl[k][w], s, a)) begin
            eh = 1; ew = 1'(w); es = 1'(k); c = mctrl[k][w];
          end
    @(negedge clk);
    chk({req, " R9 hit"}, {31'h0, hit}, {31'h0, eh});
    chk({req, " R8 win/sock"}, {30'h0, hit_win, hit_sock}, {30'h0, ew, es});
    chk({req, " R10 width/wait"}, {26'h0, hit_width, hit_wait}, {26'h0, c[12:11], c[3:0]});
    chk({req, " R10 ns"}, {16'h0, hit_wait_ns},
        eh ? 32'(int'(c[3:0]) * 70 / 2 + 14) : 32'h0);
    host_strb = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) begin
      mbase[s][w] = 0; mctrl[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) begin
      rd("R1 base", s, w, 0); rd("R1 ctrl", s, w, 1);
    end
    probe("R1 after reset", 1, 0, 16'h0000);
    // R2 / R11 readback
    wr(0, 0, 0, 16'h0308);
    wr(0, 0, 1, 16'hA0F7);
    rd("R2 base", 0, 0, 0); rd("R2 R11 ctrl", 0, 0, 1);
    wr(0, 0, 1, 16'h9003);
    rd("R11 dyn quiet", 0, 0, 1);
    // R4 range edges: base 0x308 -> 0x300..0x30F, socket 0
    wr(0, 0, 1, 16'h8803);
    probe("R4 first", 1, 0, 16'h0300);
    probe("R4 last", 1, 0, 16'h030F);
    probe("R4 below", 1, 0, 16'h02FF);
    probe("R4 above", 1, 0, 16'h0310);
    // R9 no strobe
    probe("R9 no strobe", 0, 0, 16'h0305);
    // R7 wrong socket
    probe("R7 other sock", 1, 1, 16'h0305);
    // R5 single port
    wr(1, 0, 0, 16'h03F8);
    wr(1, 0, 1, 16'hC105);
    probe("R5 exact", 1, 1, 16'h03F8);
    probe("R5 neighbour", 1, 1, 16'h03F9);
    // R6 disabled
    wr(1, 0, 1, 16'h4105);
    probe("R6 disabled", 1, 1, 16'h03F8);
    // R8 priority: window1 bank0 overlapping window0 bank0
    wr(0, 1, 0, 16'h0380);
    wr(0, 1, 1, 16'h800F);
    probe("R8 w0 over w1", 1, 0, 16'h0304);
    probe("R8 w1 alone", 1, 0, 16'h03A0);
    // bank priority: bank1 window0 selecting socket 0
    wr(1, 0, 0, 16'h0340);
    wr(1, 0, 1, 16'h8001);
    wr(0, 0, 1, 16'h0000);
    probe("R8 bank0 w1 vs bank1 w0", 1, 0, 16'h0310);
    // R4 zero base spans all
    wr(0, 0, 0, 16'h0000);
    wr(0, 0, 1, 16'h8002);
    probe("R4 zero base", 1, 0, 16'hFFFF);
    // R3 bad index
    wr(0, 2, 0, 16'h1234);
    wr(1, 3, 1, 16'hFFFF);
    rd("R3 read idx2", 0, 2, 0);
    rd("R3 read idx3", 1, 3, 1);
    rd("R3 w0 intact", 0, 0, 0);
    rd("R3 w0 ctrl intact", 1, 0, 1);
    probe("R3 no alias", 1, 0, 16'h0005);
    // random
    for (int it = 0; it < 300; it++) begin
      if (it % 20 == 0)
        for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) begin
          int e = $urandom_range(0, 6);
          logic [15:0] st = 16'($urandom) & ~16'((1 << e) - 1);
          logic [15:0] c = 16'($urandom) & 16'hE70F;
          c[10:8] = {2'b00, 1'($urandom)};
          if (e == 0) c[14] = 1; else c[14] = ($urandom_range(0, 5) == 0);
          wr(s, w, 0, (e == 0) ? st : (st | 16'(1 << (e - 1))));
          wr(s, w, 1, c);
        end
      begin
        int s = $urandom_range(0, 1);
        int w = $urandom_range(0, 1);
        logic [15:0] a = ($urandom_range(0, 3) == 0) ? 16'($urandom)
                         : mbase[s][w] + 16'($urandom_range(0, 80)) - 16'd40;
        probe("R4 R5 R7 R8 random", 1'($urandom), 1'($urandom), a);
      end
    end
    for (int s = 0; s < 2; s++) for (int w = 0; w < 2; w++) rd("R2 final ctrl", s, w, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule